// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block moves a block of data from one address range to another, one unit at a time, over a simple memory request/response port. Software (or a surrounding controller) presents a packed 32-bit configuration word together with a source start address and a destination start address, and pulses `start`. The configuration word selects a unit size of one, two or four bytes. It also selects a separate address step for each side: zero, one, two or four times the unit size. The last field is a transfer count held as the number of units minus one.

For every unit the engine first issues a read of the selected size at the current source address and waits for its response. It then issues a write of the same size carrying that data to the current destination address and waits for its acknowledge. After the acknowledge it advances both addresses by their steps. The live count is decremented in place as units complete and is visible on `live_count`, so after a run it reads zero rather than the programmed size. When the unit whose count was zero finishes, `done` pulses for one cycle. The engine then returns to idle with the final addresses held on `src_addr` and `dst_addr`.

A configuration with the reserved size code is refused at start: `err` pulses and no access is made.

Top module: `dma_chan_seq`

## Requirements
- R1: Only configuration bits 9:8 (size code), 13:12 (source step code), 15:14 (destination step code) and 25:16 (count) are used. Every other bit of `cfg` has no effect on the accesses or results.
- R2: Size codes 0, 1 and 2 give units of 1, 2 and 4 bytes. Every read and every write of a run carries that code on `req_size`. Data is right-aligned in `rsp_rdata` and `req_wdata` and is little-endian in memory.
- R3: The source address of unit k equals the source start plus k times the source step. Step code 0 gives no step, 1 gives one unit, 2 gives two units and 3 gives four units.
- R4: The destination address of unit k follows the same rule using the destination step code.
- R5: A count field of N performs exactly N+1 units, moving (N+1) times the unit size in bytes. N=0 gives one unit and N=0x3FF gives 1024 units.
- R6: `live_count` holds the programmed count in the cycle after start and steps down by one per completed unit. It reads 0 after the run.
- R7: Each unit performs a read (`req_write`=0) whose response arrives before the matching write (`req_write`=1) is issued. At most one access is outstanding. A request holds its address, size and direction until `req_ready` accepts it.
- R8: After the final unit, `done` is high for exactly one cycle and `busy` falls. `src_addr` and `dst_addr` then hold start plus (N+1) times each step.
- R9: A start with size code 3 pulses `err` for one cycle, leaves `busy` low and issues no request.
- R10: A `start` that arrives while `busy` is high is ignored, together with the configuration and addresses presented with it.
- R11: After reset `busy`, `done`, `err` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| cfg | input | 32 | Packed configuration word |
| src_start | input | AW | Source start address |
| dst_start | input | AW | Destination start address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | One-cycle reserved-size rejection pulse |
| live_count | output | CW | Remaining-units counter (minus-one encoded) |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Request byte address |
| req_size | output | 2 | Request size code |
| req_wdata | output | 32 | Write data, right-aligned |
| rsp_valid | input | 1 | Read data or write acknowledge |
| rsp_rdata | input | 32 | Read data, right-aligned |

## Verification
The bench targets the step encodings. A design that doubled instead of quadrupling for code 3, or that stepped by bytes instead of units, would put requests at the wrong addresses and would end on wrong final addresses. Single-unit runs (count 0) and a full 1024-unit run expose off-by-one errors in the minus-one count, which show up as one unit too many or too few in memory. Random stalls on `req_ready` catch a request that changes while it waits. A reserved size code that still leaks an access would be seen on the request port. So would a restart mid-run that reloads state: the copy would end at the wrong place.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   cfg,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] live_count,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_size,
  output logic [31:0]   req_wdata,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_rdata
);
  localparam int CNT_LSB = 16;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RD_WAIT, S_WR, S_WR_WAIT} state_t;

  state_t         st;
  logic [1:0]     unit, s_code, d_code;
  logic [31:0]    hold;
  logic [AW-1:0]  s_step, d_step;

  wire [1:0]    f_unit  = cfg[9:8];
  wire [1:0]    f_sinc  = cfg[13:12];
  wire [1:0]    f_dinc  = cfg[15:14];
  wire [CW-1:0] f_count = cfg[CNT_LSB +: CW];

  function automatic logic [AW-1:0] stride(input logic [1:0] code, input logic [1:0] w);
    logic [AW-1:0] b;
    b = AW'(1) << w;
    return (code == 2'd0) ? '0 : (b << (code - 2'd1));
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  assign s_step    = stride(s_code, unit);
  assign d_step    = stride(d_code, unit);
  assign busy      = (st != S_IDLE);
  assign req_valid = (st == S_RD) || (st == S_WR);
  assign req_write = (st == S_WR);
  assign req_addr  = req_write ? dst_addr : src_addr;
  assign req_size  = unit;
  assign req_wdata = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      unit       <= '0;
      s_code     <= '0;
      d_code     <= '0;
      live_count <= '0;
      src_addr   <= '0;
      dst_addr   <= '0;
      hold       <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (f_unit == 2'd3) begin
              err <= 1'b1;
            end else begin
              unit       <= f_unit;
              s_code     <= f_sinc;
              d_code     <= f_dinc;
              live_count <= f_count;
              src_addr   <= src_start;
              dst_addr   <= dst_start;
              st         <= S_RD;
            end
          end
        S_RD:      if (req_ready) st <= S_RD_WAIT;
        S_RD_WAIT:
          if (rsp_valid) begin
            hold <= rsp_rdata & lane_mask(unit);
            st   <= S_WR;
          end
        S_WR:      if (req_ready) st <= S_WR_WAIT;
        S_WR_WAIT:
          if (rsp_valid) begin
            src_addr <= src_addr + s_step;
            dst_addr <= dst_addr + d_step;
            if (live_count == '0) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              live_count <= live_count - 1'b1;
              st         <= S_RD;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] live_count,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size
);
  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_size != 2'd3);

  p_count_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || live_count == $past(live_count) || live_count == $past(live_count) - 1'b1));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_size)));

  p_req_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && live_count == '0));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !req_valid));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .live_count(live_count), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
  localparam int AW = 32;
  localparam int CW = 10;
  localparam int MB = 4096;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] cfg = '0;
  logic [AW-1:0] src_start = '0, dst_start = '0;
  logic busy, done, err, req_valid, req_write;
  logic [CW-1:0] live_count;
  logic [AW-1:0] src_addr, dst_addr, req_addr;
  logic [1:0] req_size;
  logic [31:0] req_wdata;
  logic req_ready = 0, rsp_valid = 0;
  logic [31:0] rsp_rdata = '0;

  always #2 clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW)) uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [MB];
  logic [7:0] ref_mem [MB];

  logic        run_on = 0;
  int          run_k, n_req;
  logic        run_ph;
  logic [1:0]  run_w;
  logic [AW-1:0] run_s, run_d, run_ss, run_ds;
  logic        pend = 0;
  logic [31:0] pdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] step_of(input logic [1:0] code, input logic [1:0] w);
    int m;
    m = (code == 0) ? 0 : (code == 1) ? 1 : (code == 2) ? 2 : 4;
    return AW'(m * (1 << w));
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        rsp_valid = 1; rsp_rdata = pdata; pend = 0;
      end else begin
        rsp_valid = 0;
      end
      req_ready = ($urandom % 4) != 0;
      if (req_valid && req_ready) begin
        n_req++;
        pdata = '0;
        if (run_on) begin
          chk(req_write == run_ph, "R7", "access order", req_write, run_ph);
          chk(req_size == run_w, "R2", "request size", req_size, run_w);
          chk(req_addr == (run_ph ? run_d + AW'(run_k) * run_ds : run_s + AW'(run_k) * run_ss),
              run_ph ? "R4" : "R3", "request address", req_addr,
              run_ph ? run_d + AW'(run_k) * run_ds : run_s + AW'(run_k) * run_ss);
          if (run_ph) run_k++;
          run_ph = ~run_ph;
        end
        for (int b = 0; b < (1 << req_size); b++) begin
          if (req_write) mem[(req_addr + AW'(b)) % MB] = req_wdata[8*b +: 8];
          else pdata[8*b +: 8] = mem[(req_addr + AW'(b)) % MB];
        end
        pend = 1;
      end
    end
  end

  task automatic do_run(input logic [1:0] w, input logic [1:0] si, input logic [1:0] di,
                        input int n, input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input logic [31:0] junk, input bit poke);
    logic [31:0] c;
    int cyc, bytes, bad;
    logic [AW-1:0] ss, ds;
    c = (junk & ~32'h03ff_f300) | (32'(n) << 16) | (32'(di) << 14) | (32'(si) << 12) | (32'(w) << 8);
    ss = step_of(si, w); ds = step_of(di, w);
    bytes = 1 << w;
    for (int i = 0; i < MB; i++) ref_mem[i] = mem[i];
    for (int k = 0; k <= n; k++) begin
      logic [7:0] t [4];
      for (int b = 0; b < bytes; b++) t[b] = ref_mem[(s + AW'(k) * ss + AW'(b)) % MB];
      for (int b = 0; b < bytes; b++) ref_mem[(d + AW'(k) * ds + AW'(b)) % MB] = t[b];
    end
    run_w = w; run_s = s; run_d = d; run_ss = ss; run_ds = ds;
    run_k = 0; run_ph = 0; n_req = 0; run_on = 1;
    @(negedge clk);
    cfg = c; src_start = s; dst_start = d; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R11", "busy after start", busy, 1);
    chk(live_count == CW'(n), "R6", "count loaded", live_count, n);
    if (poke) begin
      repeat (5) @(negedge clk);
      cfg = 32'h0000_1100; src_start = 32'h10; dst_start = 32'h20; start = 1;
      @(negedge clk);
      start = 0;
      chk(live_count <= CW'(n), "R6", "count not above programmed", live_count, n);
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1, "R8", "done seen", done, 1);
    chk(busy == 0, "R8", "idle at done", busy, 0);
    chk(live_count == 0, "R6", "count exhausted", live_count, 0);
    chk(src_addr == s + AW'(n + 1) * ss, "R8", "final source address", src_addr, s + AW'(n + 1) * ss);
    chk(dst_addr == d + AW'(n + 1) * ds, "R8", "final destination address", dst_addr, d + AW'(n + 1) * ds);
    chk(n_req == 2 * (n + 1), poke ? "R10" : "R5", "access count", n_req, 2 * (n + 1));
    @(negedge clk);
    chk(done == 0, "R8", "done one cycle", done, 0);
    chk(src_addr == s + AW'(n + 1) * ss, "R8", "source address held", src_addr, s + AW'(n + 1) * ss);
    run_on = 0;
    bad = 0;
    for (int i = 0; i < MB; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, junk != 0 ? "R1" : "R5", "memory image mismatches", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < MB; i++) mem[i] = 8'($urandom);
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && req_valid == 0, "R11", "reset outputs",
        {busy, done, err, req_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    do_run(2'd0, 2'd1, 2'd1, 0, 32'h100, 32'h800, 0, 0);
    do_run(2'd2, 2'd3, 2'd2, 0, 32'h200, 32'h900, 0, 0);
    do_run(2'd1, 2'd0, 2'd3, 5, 32'h300, 32'hA00, 0, 0);
    do_run(2'd2, 2'd2, 2'd0, 3, 32'h401, 32'hB03, 0, 0);
    do_run(2'd0, 2'd1, 2'd1, 1023, 32'h000, 32'hC00, 0, 0);
    do_run(2'd1, 2'd1, 2'd2, 7, 32'h500, 32'hD00, 32'hfc00_00ff, 0);
    do_run(2'd2, 2'd1, 2'd1, 10, 32'h600, 32'hE00, 0, 1);
    n_req = 0;
    @(negedge clk);
    cfg = 32'h0000_5300; start = 1;
    @(negedge clk);
    start = 0;
    chk(err == 1, "R9", "error pulse", err, 1);
    chk(busy == 0, "R9", "stays idle", busy, 0);
    repeat (8) @(negedge clk);
    chk(err == 0, "R9", "error pulse ends", err, 0);
    chk(n_req == 0, "R9", "no access", n_req, 0);
    for (int r = 0; r < 24; r++) begin
      do_run(2'($urandom % 3), 2'($urandom), 2'($urandom), int'($urandom % 16),
             AW'($urandom % MB), AW'($urandom % MB), $urandom, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule